// File: doc/BRIEF.md
# SMBus Block-Access Control Register Target

This block is a serial-bus target that holds a small bank of 8-bit control registers and reaches them only through indexed block transfers. The system clock oversamples the bus clock and data lines, finds START, repeated START and STOP, and moves whole bytes in and out of the bank. The host addresses the device, names a starting register index, and then either streams data bytes in (after announcing how many) or re-addresses the device for reading. On a read, the target first returns a byte count and then the registers in index order.

Register contents appear in parallel on a flat output bus so neighbouring logic can use them as configuration. The lowest register mirrors two status input pins. The highest register is a fixed identity byte. Everything in between can be written.

Top module: `smb_blkreg_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0). Register images are: reg1 0x47, reg2 0x00, reg3 0xFF, reg4 0xC7, reg5 0xDF, reg6 0x03. Byte k of `regs_o` is bits [8k+7:8k].
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged, i.e. 7-bit address 0x69 with R/W in bit 0. Any other address byte is not acknowledged, and the following bytes of that transfer are ignored.
- R3: A write is START, 0xD2, index N, count X, then data bytes. Every one of those bytes is acknowledged, and the data bytes land in registers N, N+1, and so on.
- R4: Once X data bytes have been received, any further data byte is not acknowledged and is not stored.
- R5: A read is START, 0xD2, index N, repeated START, 0xD3. The target then sends the count byte, followed by registers N, N+1, and so on, MSB first. The index advances after each data byte.
- R6: The count byte returned on a read is the X of the most recent write. After reset, it is 8.
- R7: Register 0 reads as {6'b0, fsel_i}. Register 7 reads as {REV_ID, 4'b0001}. Writes to register 0, register 7 or any index of 8 or more are acknowledged and discarded.
- R8: A read at an index of 8 or more returns 0x00.
- R9: A STOP ends any transfer and leaves the target idle. While idle, bus activity is ignored until a START. A START at any point releases SDA and begins a new address phase, keeping the index.
- R10: When the host answers a read byte with NACK, the target stops driving SDA and sends nothing more.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| fsel_i | input | 2 | Status pins mirrored in register 0 bits 1:0 |
| regs_o | output | 8*NREG | Register image, byte k = register k |

## Verification
The checker relies on a legal host. Host data changes only while SCL is low, except for the SDA edge that forms a START or STOP. No START or STOP is issued while the target holds SDA low. Each SCL level lasts several system clocks, so that the synchronizers see every edge. The bench model keeps to these rules with ten-clock quarter bit periods and a wired-AND data line. It moves SDA at least half a quarter period after each SCL fall, and it releases its acknowledge before the target's next bit is sampled.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK} bus_ph_e;
  typedef enum logic [2:0] {FL_ADDR, FL_IDX, FL_CNT, FL_WDAT, FL_RD} field_e;

  function automatic logic [7:0] reg_reset(input int k);
    case (k)
      1:       return 8'h47;
      3:       return 8'hFF;
      4:       return 8'hC7;
      5:       return 8'hDF;
      6:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int W = STAGES + 1;
  logic [W-1:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[W-2:0], scl_i};
      sda_p <= {sda_p[W-2:0], sda_i};
    end
  end

  logic scl_q, sda_q;
  assign scl_s    = scl_p[W-2];
  assign sda_s    = sda_p[W-2];
  assign scl_q    = scl_p[W-1];
  assign sda_q    = sda_p[W-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_blk_pkg::*;
#(
  parameter int         NREG      = 8,
  parameter logic [3:0] REV_ID    = 4'h0,
  parameter logic [3:0] VENDOR_ID = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_idx,
  input  logic [1:0]        fsel_i,
  output logic [7:0]        rd_data,
  output logic [8*NREG-1:0] regs_o
);
  localparam int         IW   = $clog2(NREG);
  localparam logic [7:0] LAST = 8'(NREG - 1);

  logic [7:0] img [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == 0) begin : g_status
      assign img[k] = {6'b0, fsel_i};
    end else if (k == NREG - 1) begin : g_ident
      assign img[k] = {REV_ID, VENDOR_ID};
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reg_reset(k);
        else if (wr_req && wr_idx == 8'(k)) q <= wr_data;
      end
      assign img[k] = q;
    end
    assign regs_o[8*k +: 8] = img[k];
  end

  assign rd_data = (rd_idx <= LAST) ? img[rd_idx[IW-1:0]] : 8'h00;
endmodule

// File: rtl/smb_blk_engine.sv
module smb_blk_engine
  import smb_blk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] CNT_RST  = 8'd8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_req,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] idx
);
  bus_ph_e    ph;
  field_e     fld;
  logic [2:0] bitn;
  logic       got8, mack;
  logic [7:0] sh, tx, last_cnt, left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;  fld <= FL_ADDR;  bitn <= '0;  got8 <= 1'b0;  mack <= 1'b0;
      sh <= '0;  tx <= '0;  last_cnt <= CNT_RST;  left <= '0;  idx <= '0;
      sda_oe <= 1'b0;  wr_req <= 1'b0;  wr_idx <= '0;  wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_p) begin
        ph <= PH_RX;  fld <= FL_ADDR;  bitn <= '0;  got8 <= 1'b0;  sda_oe <= 1'b0;
      end else if (stop_p) begin
        ph <= PH_IDLE;  sda_oe <= 1'b0;
      end else begin
        case (ph)
          PH_RX: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              if (bitn == 3'd7) got8 <= 1'b1;
              else bitn <= bitn + 3'd1;
            end else if (scl_fall && got8) begin
              got8 <= 1'b0;  bitn <= '0;  ph <= PH_ACK;  sda_oe <= 1'b1;
              case (fld)
                FL_ADDR: begin
                  if (sh[7:1] != DEV_ADDR) begin
                    ph <= PH_IDLE;  sda_oe <= 1'b0;
                  end else begin
                    fld <= sh[0] ? FL_RD : FL_IDX;
                  end
                end
                FL_IDX: begin idx <= sh; fld <= FL_CNT; end
                FL_CNT: begin last_cnt <= sh; left <= sh; fld <= FL_WDAT; end
                FL_WDAT: begin
                  if (left == 8'd0) begin
                    ph <= PH_IDLE;  sda_oe <= 1'b0;
                  end else begin
                    left <= left - 8'd1;  wr_req <= 1'b1;  wr_idx <= idx;
                    wr_data <= sh;  idx <= idx + 8'd1;
                  end
                end
                default: begin ph <= PH_IDLE; sda_oe <= 1'b0; end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (fld == FL_RD) begin
                ph <= PH_TX;  tx <= last_cnt;  sda_oe <= ~last_cnt[7];
              end else begin
                ph <= PH_RX;  sda_oe <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitn == 3'd7) begin
                bitn <= '0;  ph <= PH_MACK;  sda_oe <= 1'b0;
              end else begin
                bitn <= bitn + 3'd1;  tx <= {tx[6:0], 1'b0};  sda_oe <= ~tx[6];
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                ph <= PH_TX;  tx <= rd_data;  sda_oe <= ~rd_data[7];  idx <= idx + 8'd1;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NREG      = 8,
  parameter logic [3:0] REV_ID    = 4'h0,
  parameter logic [3:0] VENDOR_ID = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        fsel_i,
  output logic [8*NREG-1:0] regs_o
);
  localparam logic [7:0] CNT_RST = 8'(NREG);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic       wr_req;
  logic [7:0] wr_idx, wr_data, idx, rd_data;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  smb_blk_engine #(.DEV_ADDR(DEV_ADDR), .CNT_RST(CNT_RST)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data), .idx(idx)
  );

  smb_regfile #(.NREG(NREG), .REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(idx), .fsel_i(fsel_i), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/smb_blkreg_chk.sv
module smb_blkreg_chk #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_oe,
  input logic              start_p,
  input logic              stop_p,
  input logic              wr_req,
  input logic [8*NREG-1:0] regs
);
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe); // R9
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !sda_oe); // R9
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl); // R11
  AST_REG_CHANGE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs[8*NREG-9:8]) |-> $past(wr_req)); // R3
endmodule

bind smb_blkreg_target smb_blkreg_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .sda_oe(sda_oe),
  .start_p(start_p), .stop_p(stop_p), .wr_req(wr_req), .regs(regs_o)
);

// File: tb/smb_blkreg_target_tb.sv
`timescale 1ns/1ps
module smb_blkreg_target_tb;
  localparam int Q = 40;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic [1:0]  fsel = 2'b10;
  logic        sda_oe;
  logic [63:0] regs_o;
  wire         sda_line = sda_h & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 0, hi_glitch = 0;
  logic [7:0] expv [8];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [9];
  bit         dack [8];

  always #2 clk = ~clk;

  smb_blkreg_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .fsel_i(fsel), .regs_o(regs_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_img(input string tag);
    for (int k = 1; k < 7; k++) chk(tag, regs_o[8*k +: 8], expv[k]);
    chk({tag, " R7 id"}, regs_o[63:56], 8'h01);
    chk({tag, " R7 status"}, regs_o[7:0], {6'b0, fsel});
  endtask

  task automatic bus_start();
    sda_h = 1; #Q; scl = 1; #Q; sda_h = 0; #Q; scl = 0; #(Q/2);
  endtask

  task automatic bus_stop();
    sda_h = 0; #Q; scl = 1; #Q; sda_h = 1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; #Q; scl = 1; #(2*Q); scl = 0; #(Q/2);
    end
    sda_h = 1; #Q; scl = 1; #Q; acked = (sda_line == 1'b0); #Q; scl = 0; #(Q/2);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    logic s1, s2;
    sda_h = 1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1; #Q; s1 = sda_line; #Q; s2 = sda_line;
      if (s1 !== s2) hi_glitch = 1;
      b[i] = s1; scl = 0;
    end
    #(Q/2); sda_h = last ? 1'b1 : 1'b0; #Q; scl = 1; #(2*Q); scl = 0; #(Q/2); sda_h = 1;
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt, input int nb,
                          output bit hdr_ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0); send_byte(idx, a1); send_byte(cnt, a2);
    hdr_ok = a0 & a1 & a2;
    for (int i = 0; i < nb; i++) send_byte(wbuf[i], dack[i]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] idx, input int nb, output bit hdr_ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0); send_byte(idx, a1);
    bus_start();
    send_byte(8'hD3, a2);
    hdr_ok = a0 & a1 & a2;
    for (int i = 0; i <= nb; i++) recv_byte(i == nb, rbuf[i]);
    #(Q/2);
    chk("R10 sda released after NACK", {7'b0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) expv[k] = 8'h00;
    expv[1] = 8'h47; expv[3] = 8'hFF; expv[4] = 8'hC7; expv[5] = 8'hDF; expv[6] = 8'h03;
    chk("R1 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    chk_img("R1 reset image");
  endtask

  task automatic t_count_after_reset();
    bit ok;
    do_read(8'd0, 2, ok);
    chk("R5 read header acks", {7'b0, ok}, 8'h01);
    chk("R6 count after reset", rbuf[0], 8'd8);
    chk("R7 reg0 status read", rbuf[1], {6'b0, fsel});
    chk("R5 reg1 read", rbuf[2], expv[1]);
  endtask

  task automatic t_write_basic();
    bit ok;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hE1;
    do_write(8'd2, 8'd3, 3, ok);
    chk("R3 write header acks", {7'b0, ok}, 8'h01);
    for (int i = 0; i < 3; i++) chk("R3 data ack", {7'b0, dack[i]}, 8'h01);
    expv[2] = 8'hA5; expv[3] = 8'h3C; expv[4] = 8'hE1;
    chk_img("R3 image after write");
  endtask

  task automatic t_read_back();
    bit ok;
    do_read(8'd2, 3, ok);
    chk("R6 count from last write", rbuf[0], 8'd3);
    for (int i = 0; i < 3; i++) chk("R5 read data", rbuf[i+1], expv[2+i]);
    chk("R11 SDA stable while SCL high", {7'b0, hi_glitch}, 8'h00);
  endtask

  task automatic t_write_ro();
    bit ok;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'd6, 8'd3, 3, ok);
    for (int i = 0; i < 3; i++) chk("R7 write acked", {7'b0, dack[i]}, 8'h01);
    expv[6] = 8'h11;
    chk_img("R7 read-only ignored");
    wbuf[0] = 8'h77;
    do_write(8'd0, 8'd1, 1, ok);
    chk("R7 reg0 write acked", {7'b0, dack[0]}, 8'h01);
    chk_img("R7 reg0 write ignored");
  endtask

  task automatic t_read_past();
    bit ok;
    do_read(8'd6, 3, ok);
    chk("R6 count", rbuf[0], 8'd1);
    chk("R5 reg6", rbuf[1], 8'h11);
    chk("R7 reg7 id", rbuf[2], 8'h01);
    chk("R8 index 8 reads zero", rbuf[3], 8'h00);
  endtask

  task automatic t_over_count();
    bit ok;
    wbuf[0] = 8'h5A; wbuf[1] = 8'h99;
    do_write(8'd1, 8'd1, 2, ok);
    chk("R4 first byte acked", {7'b0, dack[0]}, 8'h01);
    chk("R4 extra byte not acked", {7'b0, dack[1]}, 8'h00);
    expv[1] = 8'h5A;
    chk_img("R4 extra byte not stored");
  endtask

  task automatic t_bad_addr();
    bit a0, a1;
    bus_start();
    send_byte(8'hA4, a0);
    send_byte(8'h03, a1);
    bus_stop();
    chk("R2 foreign address not acked", {7'b0, a0}, 8'h00);
    chk("R2 following byte ignored", {7'b0, a1}, 8'h00);
    chk_img("R2 image unchanged");
  endtask

  task automatic t_abort();
    bit a0, a1, a2, a3, a4, ok;
    bus_start();
    send_byte(8'hD2, a0); send_byte(8'd3, a1); send_byte(8'd2, a2); send_byte(8'h96, a3);
    bus_stop();
    expv[3] = 8'h96;
    send_byte(8'hD2, a4);
    chk("R9 idle after STOP ignores bytes", {7'b0, a4}, 8'h00);
    chk_img("R9 abort keeps partial write only");
    wbuf[0] = 8'h66;
    do_write(8'd4, 8'd1, 1, ok);
    chk("R9 new START works", {7'b0, ok & dack[0]}, 8'h01);
    expv[4] = 8'h66;
    chk_img("R9 image after new write");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #41; #400; rst_n = 1; #(Q*4);
    t_reset();
    t_count_after_reset();
    t_write_basic();
    t_read_back();
    t_write_ro();
    t_read_past();
    t_over_count();
    t_bad_addr();
    fsel = 2'b01; #Q;
    t_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule